// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timing Controller

This block decides, clock by clock, when the gate of a secondary-side synchronous rectifier switch in a flyback converter is driven. It reads three digitized comparator flags:
- the sense voltage is above an upper arming level;
- the sense voltage is below a lower trigger level;
- an external timing ramp has discharged to zero.

It produces a gate-enable output and a low-power flag.

A conduction cycle may start only once the controller is armed. Arming needs the sense flag to stay above the arming level for an unbroken blanking interval, which rejects resonant ringing in discontinuous operation. The gate switches off when the ramp reports zero. Each turn-off is followed by a lockout. The controller times every conduction interval. A long enough run of consecutive short intervals moves it into a low-power mode, in which the gate is held off. Cycles are still timed in that mode, and one long interval brings the controller back to normal operation.

All durations are given in nanoseconds and converted to clock cycles from a clock-frequency parameter. With the default 20 MHz clock the durations are:

| Duration | Nanoseconds | Clock cycles |
|---|---|---|
| Blanking | 1000 | 20 |
| Lockout | 2500 | 50 |
| Short-cycle limit | 4800 | 96 |

The default run length is 9.

Top module: `sr_gate_ctrl`

## Requirements
- R1: While reset is active, and on the first clock after its release, gate_en_o and green_o are both 0.
- R2: Each comparator input passes through a two-stage synchronizer. A change of sense_lo_i or ramp_zero_i that is first sampled on a rising edge reaches gate_en_o on the third rising edge, counting that one.
- R3: The controller arms only after sense_hi_i has been sampled high on ARM_CYC consecutive cycles. Any low sample before that restarts the count. Once armed, it stays armed when sense_hi_i falls.
- R4: A trigger (sense_lo_i high) that arrives while the controller is not armed leaves gate_en_o at 0.
- R5: When armed, idle and not locked out, a trigger starts a conduction cycle and gate_en_o goes to 1. Starting a cycle consumes the arming, so every cycle needs a fresh blanking hold.
- R6: gate_en_o drops to 0 when ramp_zero_i is seen during conduction.
- R7: After every turn-off, no conduction cycle starts for LOCK_CYC cycles. The gate stays low for at least LOCK_CYC+1 cycles, even if the controller is armed and the trigger is held.
- R8: A conduction cycle that lasts fewer than SHORT_CYC clock cycles is short. On the (SHORT_RUN+1)-th consecutive short cycle, green_o goes to 1 on the edge of its turn-off.
- R9: A cycle lasting SHORT_CYC or more clears the consecutive short count. Nine shorts, then one long, then nine more shorts do not set green_o.
- R10: While green_o is 1, gate_en_o stays 0. Conduction cycles are still sequenced and timed.
- R11: A long cycle seen while green_o is 1 clears green_o and the short count, so the next armed trigger drives the gate again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sense_hi_i | input | 1 | Sense voltage above the arming level |
| sense_lo_i | input | 1 | Sense voltage below the trigger level |
| ramp_zero_i | input | 1 | Timing ramp has discharged to zero |
| gate_en_o | output | 1 | Rectifier gate drive enable |
| green_o | output | 1 | Low-power mode flag |

## Verification
The hardest state to reach from the ports is low-power entry and exit. It needs ten back-to-back conduction cycles. Each one must be armed by a full blanking hold, must wait out the lockout, and must have a controlled length on the correct side of the short-cycle limit. The stimulus builds every cycle from one parameterized task: arming hold, trigger, a chosen conduction length, then a ramp-zero pulse and the lockout wait. It chains nine shorts and a long to prove that the run resets, then ten shorts to enter the mode. A further armed cycle inside the mode must leave the gate dark, and a final long cycle exits the mode and restores gate drive.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COND = 2'd1,
    PH_LOCK = 2'd2
  } phase_t;

  // Convert a duration in ns to clock cycles, never below 2.
  function automatic int ns_to_cyc(input int clk_khz, input int ns);
    int c;
    c = (clk_khz * ns) / 1000000;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/sr_sync2.sv
module sr_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end
    assign q_o[b] = sync_q;
  end
endmodule

// File: rtl/sr_arm_timer.sv
module sr_arm_timer #(
  parameter int HOLD_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_hi_i,
  input  logic take_i,
  output logic armed_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (take_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (!sense_hi_i) begin
      cnt_d = '0;
    end else if (!armed_q) begin
      if (cnt_q == LAST) begin
        armed_d = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  // Independent run-length counter of the synchronized sense flag.
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!sense_hi_i)     run_q <= '0;
    else if (run_q != LAST)   run_q <= run_q + 1'b1;
  end

  a_r3_arm_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> ($past(sense_hi_i) && $past(run_q) == LAST));
  a_r5_take_clears_arm: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !armed_o);
endmodule

// File: rtl/sr_cycle_meter.sv
module sr_cycle_meter #(
  parameter int SHORT_CYC = 96,
  parameter int SHORT_RUN = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_i,
  input  logic done_i,
  output logic green_o
);
  localparam int DW = $clog2(SHORT_CYC + 1);
  localparam int RW = $clog2(SHORT_RUN + 2);
  localparam logic [DW-1:0] DSAT = DW'(SHORT_CYC - 1);
  localparam logic [RW-1:0] RMAX = RW'(SHORT_RUN);

  logic [DW-1:0] dur_q, dur_d;
  logic [RW-1:0] run_q, run_d;
  logic          grn_q, grn_d;
  logic          is_long;

  assign is_long = (dur_q == DSAT);

  always_comb begin
    dur_d = dur_q;
    run_d = run_q;
    grn_d = grn_q;
    if (done_i) begin
      dur_d = '0;
      if (is_long) begin
        run_d = '0;
        grn_d = 1'b0;
      end else if (run_q == RMAX) begin
        grn_d = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end else if (on_i && !is_long) begin
      dur_d = dur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q <= '0;
      run_q <= '0;
      grn_q <= 1'b0;
    end else begin
      dur_q <= dur_d;
      run_q <= run_d;
      grn_q <= grn_d;
    end
  end

  assign green_o = grn_q;

  a_r8_green_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(green_o) |-> ($past(done_i) && $past(run_q) == RMAX));
  a_r11_exit_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(green_o) |-> (run_q == '0));
  a_r9_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RMAX);
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import sr_gate_pkg::*;
#(
  parameter int CLK_KHZ   = 20000,
  parameter int ARM_NS    = 1000,
  parameter int LOCK_NS   = 2500,
  parameter int SHORT_NS  = 4800,
  parameter int SHORT_RUN = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_hi_i,
  input  logic sense_lo_i,
  input  logic ramp_zero_i,
  output logic gate_en_o,
  output logic green_o
);
  localparam int ARM_CYC   = ns_to_cyc(CLK_KHZ, ARM_NS);
  localparam int LOCK_CYC  = ns_to_cyc(CLK_KHZ, LOCK_NS);
  localparam int SHORT_CYC = ns_to_cyc(CLK_KHZ, SHORT_NS);
  localparam int LW        = $clog2(LOCK_CYC + 1);
  localparam logic [LW-1:0] LLAST = LW'(LOCK_CYC - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [2:0] sync_v;
  logic       s_hi, s_lo, s_zero;

  sr_sync2 #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d_i   ({ramp_zero_i, sense_lo_i, sense_hi_i}),
    .q_o   (sync_v)
  );
  assign {s_zero, s_lo, s_hi} = sync_v;

  phase_t        ph_q, ph_d;
  logic [LW-1:0] lk_q, lk_d;
  logic          armed, take, done, green;

  assign take = (ph_q == PH_IDLE) && armed && s_lo;
  assign done = (ph_q == PH_COND) && s_zero;

  sr_arm_timer #(.HOLD_CYC(ARM_CYC)) u_arm (
    .clk        (clk),
    .rst_n      (rst_q),
    .sense_hi_i (s_hi),
    .take_i     (take),
    .armed_o    (armed)
  );

  sr_cycle_meter #(.SHORT_CYC(SHORT_CYC), .SHORT_RUN(SHORT_RUN)) u_meter (
    .clk     (clk),
    .rst_n   (rst_q),
    .on_i    (ph_q == PH_COND),
    .done_i  (done),
    .green_o (green)
  );

  always_comb begin
    ph_d = ph_q;
    lk_d = lk_q;
    unique case (ph_q)
      PH_IDLE: if (take) ph_d = PH_COND;
      PH_COND: if (s_zero) begin
        ph_d = PH_LOCK;
        lk_d = '0;
      end
      PH_LOCK: if (lk_q == LLAST) ph_d = PH_IDLE;
               else               lk_d = lk_q + 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ph_q <= PH_IDLE;
      lk_q <= '0;
    end else begin
      ph_q <= ph_d;
      lk_q <= lk_d;
    end
  end

  assign gate_en_o = (ph_q == PH_COND) && !green;
  assign green_o   = green;

  // Cycles of gate-low time since the last turn-off, saturating.
  logic [LW-1:0] off_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)                        off_q <= LW'(LOCK_CYC);
    else if (gate_en_o)                off_q <= '0;
    else if (off_q != LW'(LOCK_CYC))   off_q <= off_q + 1'b1;
  end

  a_r7_lockout_held: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(gate_en_o) |-> (off_q == LW'(LOCK_CYC)));
  a_r6_off_on_zero: assert property (@(posedge clk) disable iff (!rst_q)
    (gate_en_o && s_zero) |=> !gate_en_o);
  a_r4_on_needs_arm: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(gate_en_o) |-> $past(armed));
  a_r10_green_gate_off: assert property (@(posedge clk) disable iff (!rst_q)
    green_o |-> !gate_en_o);
endmodule

// File: tb/sr_gate_ctrl_tb.sv
module sr_gate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ARM = 20, LOCK = 50, SHORT = 96, RUN = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b0, lo = 1'b0, zr = 1'b0;
  logic gate, grn;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sense_hi_i(hi), .sense_lo_i(lo),
    .ramp_zero_i(zr), .gate_en_o(gate), .green_o(grn)
  );

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  bit saw_gate = 0;

  // Behavioural reference model
  int rp [2];
  int qh [$], ql [$], qz [$];
  int st, acnt, armed, lcnt, dur, sc, mg;

  task automatic model_clear();
    qh = '{0, 0}; ql = '{0, 0}; qz = '{0, 0};
    st = 0; acnt = 0; armed = 0; lcnt = 0; dur = 0; sc = 0; mg = 0;
  endtask

  initial begin
    rp[0] = 0; rp[1] = 0;
    model_clear();
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp[0] = 0; rp[1] = 0;
      model_clear();
    end else begin
      if (rp[1] == 0) begin
        model_clear();
      end else begin
        int s_hi, s_lo, s_z, take, done;
        s_hi = qh[0]; s_lo = ql[0]; s_z = qz[0];
        take = (st == 0 && armed == 1 && s_lo == 1);
        done = (st == 1 && s_z == 1);
        if (done) begin
          if (dur >= SHORT - 1) begin sc = 0; mg = 0; end
          else if (sc == RUN) mg = 1;
          else sc++;
          dur = 0;
        end else if (st == 1 && dur < SHORT - 1) dur++;
        if (take) begin acnt = 0; armed = 0; end
        else if (!s_hi) acnt = 0;
        else if (!armed) begin
          if (acnt == ARM - 1) begin armed = 1; acnt = 0; end
          else acnt++;
        end
        case (st)
          0: if (take) st = 1;
          1: if (s_z) begin st = 2; lcnt = 0; end
          default: if (lcnt == LOCK - 1) st = 0; else lcnt++;
        endcase
        void'(qh.pop_front()); qh.push_back(int'(hi));
        void'(ql.pop_front()); ql.push_back(int'(lo));
        void'(qz.pop_front()); qz.push_back(int'(zr));
      end
      rp[1] = rp[0]; rp[0] = 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    int eg;
    cyc++;
    eg = (st == 1 && mg == 0) ? 1 : 0;
    check(int'(gate) == eg, tag, "gate_en_o", int'(gate), eg);
    check(int'(grn) == mg, tag, "green_o", int'(grn), mg);
    if (gate) saw_gate = 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_cycle(input int arm_len, input int on_len);
    hi = 1'b1; tick(arm_len);
    hi = 1'b0; tick(3);
    lo = 1'b1; tick(on_len);
    lo = 1'b0; zr = 1'b1; tick(2);
    zr = 1'b0; tick(LOCK + 10);
  endtask

  initial begin
    tick(3);
    tag = "R1";
    check(gate == 1'b0 && grn == 1'b0, "R1", "outputs in reset", int'(gate), 0);
    rst_n = 1'b1;
    tick(1);
    check(gate == 1'b0 && grn == 1'b0, "R1", "outputs after release", int'(grn), 0);
    tick(5);

    // R4: trigger without arming
    tag = "R4"; saw_gate = 0;
    one_cycle(10, 30);
    check(saw_gate == 0, "R4", "unarmed trigger drove gate", int'(saw_gate), 0);

    // R3: interrupted hold restarts the blanking count
    tag = "R3"; saw_gate = 0;
    hi = 1'b1; tick(15); hi = 1'b0; tick(1);
    one_cycle(15, 30);
    check(saw_gate == 0, "R3", "broken hold armed", int'(saw_gate), 0);

    // R2/R5/R6: normal cycle with exact latency
    tag = "R5"; saw_gate = 0;
    hi = 1'b1; tick(ARM + 5); hi = 1'b0; tick(3);
    lo = 1'b1; tick(2);
    check(gate == 1'b0, "R2", "gate before third edge", int'(gate), 0);
    tick(1);
    check(gate == 1'b1, "R2", "gate on third edge", int'(gate), 1);
    tick(117);
    tag = "R6";
    lo = 1'b0; zr = 1'b1; tick(2);
    check(gate == 1'b1, "R6", "gate before ramp sync", int'(gate), 1);
    tick(1);
    check(gate == 1'b0, "R6", "gate off after ramp zero", int'(gate), 0);
    zr = 1'b0;

    // R7: arm during lockout, hold trigger; gate waits for lockout end
    tag = "R7";
    hi = 1'b1; tick(ARM + 2); hi = 1'b0; lo = 1'b1;
    begin
      int waited = 0;
      while (!gate && waited < 200) begin tick(1); waited++; end
      check(waited + ARM + 3 >= LOCK + 1, "R7", "gate-low span", waited + ARM + 3, LOCK + 1);
    end
    tick(20); lo = 1'b0; zr = 1'b1; tick(2); zr = 1'b0; tick(LOCK + 10);

    // R5: arming consumed, a bare trigger does nothing
    tag = "R5"; saw_gate = 0;
    lo = 1'b1; tick(20); lo = 1'b0; tick(5);
    check(saw_gate == 0, "R5", "trigger reused old arming", int'(saw_gate), 0);

    // R9: nine shorts, one long, nine shorts -> no low-power mode
    tag = "R9";
    for (int i = 0; i < RUN; i++) one_cycle(ARM + 2, 40);
    one_cycle(ARM + 2, 120);
    for (int i = 0; i < RUN; i++) one_cycle(ARM + 2, 40);
    check(grn == 1'b0, "R9", "green after broken run", int'(grn), 0);

    // R8: the tenth consecutive short enters low-power mode
    tag = "R8";
    one_cycle(ARM + 2, 40);
    check(grn == 1'b1, "R8", "green after run", int'(grn), 1);

    // R10: gate held off in low-power mode
    tag = "R10"; saw_gate = 0;
    one_cycle(ARM + 2, 40);
    check(saw_gate == 0 && grn == 1'b1, "R10", "gate while green", int'(saw_gate), 0);

    // R11: a long cycle leaves the mode; the next cycle drives the gate
    tag = "R11";
    one_cycle(ARM + 2, 120);
    check(grn == 1'b0, "R11", "green after long cycle", int'(grn), 0);
    saw_gate = 0;
    one_cycle(ARM + 2, 40);
    check(saw_gate == 1 && grn == 1'b0, "R11", "gate after exit", int'(saw_gate), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule